// File: doc/BRIEF.md
# Bank Latch and Mode-Dependent Address Remap

This block sits between a CPU that drives a 16-bit address bus and carries its bank byte on the shared data bus during the low phase of its phase clock, and the memory system. While the phase clock is low, the block captures the data byte as the upper eight address bits. It joins that byte with the 16-bit bus address to form a 24-bit physical address.

While the CPU's emulation-mode output is asserted, the block exchanges physical bits 15 and 21. This makes a ROM that sits at $200000 in native mode visible at $008000 after reset. At that point the program bank is zero and the CPU starts in emulation mode, so it can only fetch from bank $00.

From the remapped address the block decodes a ROM select for $200000–$3FFFFF and a RAM select for $000000–$1FFFFF. Both selects are enabled only while the phase clock is high. The block runs on a system clock that is faster than the phase clock. The phase clock arrives as a level that the block samples on each system clock edge.

Top module: `bank_remap_decoder`

## Requirements
- R1: On each rising `clk` edge where `phi2` is 0, the bank register loads `data_in`. The new bank byte appears in `phys_addr[23:16]` (native mode) after that edge. When the data byte changes several times during one low phase, the last value before `phi2` rises is the one kept.
- R2: On a rising `clk` edge where `phi2` is 1, the bank register keeps its value, whatever `data_in` does.
- R3: On a rising `clk` edge with `rst` high, the bank register is cleared to $00. This applies whatever the level of `phi2`.
- R4: When `emu` is 0, `phys_addr` equals `{bank, addr_in}` with no change.
- R5: When `emu` is 1, `phys_addr[21]` carries `addr_in[15]`, and `phys_addr[15]` carries bank bit 5 (raw bit 21). All other bits pass through unchanged. As a result, CPU address $008000 maps to physical $200000.
- R6: `emu` acts combinationally: a change of `emu` changes `phys_addr` and the selects with no clock edge in between.
- R7: `rom_cs` is 1 exactly when `phi2` is 1 and `phys_addr[23:21]` is 3'b001.
- R8: `ram_cs` is 1 exactly when `phi2` is 1 and `phys_addr[23:21]` is 3'b000.
- R9: At physical addresses of $400000 and above, neither select is asserted. The two selects are never 1 together.
- R10: While `phi2` is 0, both selects are 0, even for addresses that decode to ROM or RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the CPU phase clock |
| rst | input | 1 | Synchronous active-high reset of the bank register |
| phi2 | input | 1 | CPU phase clock level; low = bank byte on data bus |
| data_in | input | 8 | CPU data bus, carrying the bank byte while `phi2` is low |
| addr_in | input | 16 | CPU address bus |
| emu | input | 1 | CPU emulation-mode output; 1 enables the bit 15/21 exchange |
| phys_addr | output | 24 | Remapped physical address |
| rom_cs | output | 1 | ROM select, active high |
| ram_cs | output | 1 | RAM select, active high |

## Verification
The assertions assume two things about the phase clock. First, it is a level that is stable at each rising `clk` edge. Second, it is low for at least one edge in each bus cycle, so every capture and hold property is judged against that edge's sampled level. The bench meets this by driving `phi2`, `data_in`, `addr_in` and `emu` only on falling `clk` edges and sampling about one nanosecond later. For every address it also holds `phi2` low across at least one rising edge before raising it. The combinational paths (`emu` swap and decode) are checked before any further rising edge, so they are observed apart from the bank register.

// File: rtl/bank_remap_pkg.sv
package bank_remap_pkg;

    localparam int CPU_ADDR_W = 16;
    localparam int BANK_W     = 8;
    localparam int PHYS_W     = CPU_ADDR_W + BANK_W;

    // bits exchanged in emulation mode
    localparam int SWAP_LO = 15;
    localparam int SWAP_HI = 21;

    // region decode on the top physical bits
    localparam int              TAG_W   = 3;
    localparam logic [TAG_W-1:0] ROM_TAG = 3'b001;
    localparam logic [TAG_W-1:0] RAM_TAG = 3'b000;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_RAM  = 2'd1,
        REGION_ROM  = 2'd2
    } region_e;

endpackage

// File: rtl/bank_capture.sv
module bank_capture #(
    parameter int W = bank_remap_pkg::BANK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         phi2,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] bank_o
);

    typedef struct packed {
        logic [W-1:0] bank;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!phi2) begin
            st_d.bank = data_in;   // transparent while phase clock low
        end
        if (rst) begin
            st_d.bank = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bank_o = st_q.bank;

endmodule

// File: rtl/addr_swap.sv
module addr_swap #(
    parameter int W  = bank_remap_pkg::PHYS_W,
    parameter int LO = bank_remap_pkg::SWAP_LO,
    parameter int HI = bank_remap_pkg::SWAP_HI
) (
    input  logic         emu,
    input  logic [W-1:0] raw_addr,
    output logic [W-1:0] phys_addr
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == LO) begin : g_lo
            assign phys_addr[i] = emu ? raw_addr[HI] : raw_addr[i];
        end else if (i == HI) begin : g_hi
            assign phys_addr[i] = emu ? raw_addr[LO] : raw_addr[i];
        end else begin : g_pass
            assign phys_addr[i] = raw_addr[i];
        end
    end

endmodule

// File: rtl/region_decode.sv
module region_decode
    import bank_remap_pkg::*;
#(
    parameter int W = PHYS_W
) (
    input  logic         phi2,
    input  logic [W-1:0] phys_addr,
    output logic         rom_cs,
    output logic         ram_cs
);

    logic [TAG_W-1:0] tag;
    region_e          region;

    assign tag = phys_addr[W-1 -: TAG_W];

    always_comb begin
        if (tag == ROM_TAG) begin
            region = REGION_ROM;
        end else if (tag == RAM_TAG) begin
            region = REGION_RAM;
        end else begin
            region = REGION_NONE;
        end
    end

    assign rom_cs = phi2 && (region == REGION_ROM);
    assign ram_cs = phi2 && (region == REGION_RAM);

endmodule

// File: rtl/bank_remap_decoder.sv
module bank_remap_decoder
    import bank_remap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  phi2,
    input  logic [BANK_W-1:0]     data_in,
    input  logic [CPU_ADDR_W-1:0] addr_in,
    input  logic                  emu,
    output logic [PHYS_W-1:0]     phys_addr,
    output logic                  rom_cs,
    output logic                  ram_cs
);

    logic [BANK_W-1:0] bank_q;
    logic [PHYS_W-1:0] raw_addr;

    bank_capture #(.W(BANK_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .data_in (data_in),
        .bank_o  (bank_q)
    );

    assign raw_addr = {bank_q, addr_in};

    addr_swap #(.W(PHYS_W), .LO(SWAP_LO), .HI(SWAP_HI)) u_swap (
        .emu       (emu),
        .raw_addr  (raw_addr),
        .phys_addr (phys_addr)
    );

    region_decode #(.W(PHYS_W)) u_decode (
        .phi2      (phi2),
        .phys_addr (phys_addr),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs)
    );

endmodule

// File: rtl/bank_remap_checker.sv
module bank_remap_checker
    import bank_remap_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  phi2,
    input logic [BANK_W-1:0]     data_in,
    input logic [CPU_ADDR_W-1:0] addr_in,
    input logic                  emu,
    input logic [BANK_W-1:0]     bank,
    input logic [PHYS_W-1:0]     phys_addr,
    input logic                  rom_cs,
    input logic                  ram_cs
);

    localparam int BANK_HI_BIT = SWAP_HI - CPU_ADDR_W;

    // R1: low phase loads the data byte
    assert_capture_low_R1: assert property (@(posedge clk) disable iff (rst)
        !phi2 |=> bank == $past(data_in));

    // R2: high phase holds
    assert_hold_high_R2: assert property (@(posedge clk) disable iff (rst)
        phi2 |=> $stable(bank));

    // R3: reset clears bank
    assert_reset_clear_R3: assert property (@(posedge clk)
        rst |=> bank == '0);

    // R4: native mode is a plain concatenation
    assert_native_concat_R4: assert property (@(posedge clk) disable iff (rst)
        !emu |-> phys_addr == {bank, addr_in});

    // R5: emulation exchanges the two bits
    assert_emu_swap_R5: assert property (@(posedge clk) disable iff (rst)
        emu |-> (phys_addr[SWAP_HI] == addr_in[SWAP_LO]) &&
                (phys_addr[SWAP_LO] == bank[BANK_HI_BIT]));

    // R9: selects exclusive
    assert_cs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({rom_cs, ram_cs}) <= 1);

    // R10: no selects in low phase
    assert_no_cs_low_R10: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> !rom_cs && !ram_cs);

    // R7: ROM select matches region
    assert_rom_region_R7: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> phys_addr[PHYS_W-1 -: TAG_W] == ROM_TAG);

    // R8: RAM select matches region
    assert_ram_region_R8: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> phys_addr[PHYS_W-1 -: TAG_W] == RAM_TAG);

endmodule

bind bank_remap_decoder bank_remap_checker i_checker (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .data_in   (data_in),
    .addr_in   (addr_in),
    .emu       (emu),
    .bank      (bank_q),
    .phys_addr (phys_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs)
);

// File: tb/test_bank_remap_decoder.sv
module test_bank_remap_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        phi2;
    logic [7:0]  data_in;
    logic [15:0] addr_in;
    logic        emu;
    logic [23:0] phys_addr;
    logic        rom_cs;
    logic        ram_cs;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    bank_remap_decoder i_bank_remap_decoder (
        .clk       (clk),
        .rst       (rst),
        .phi2      (phi2),
        .data_in   (data_in),
        .addr_in   (addr_in),
        .emu       (emu),
        .phys_addr (phys_addr),
        .rom_cs    (rom_cs),
        .ram_cs    (ram_cs)
    );

    typedef struct packed {
        logic [7:0]  bank;
        logic [15:0] addr;
        logic        emu;
        logic [23:0] phys;
        logic        rom;
        logic        ram;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'h8000, 1'b1, 24'h200000, 1'b1, 1'b0},
        '{8'h00, 16'h8000, 1'b0, 24'h008000, 1'b0, 1'b1},
        '{8'h20, 16'h8006, 1'b0, 24'h208006, 1'b1, 1'b0},
        '{8'h20, 16'h8006, 1'b1, 24'h208006, 1'b1, 1'b0},
        '{8'h20, 16'h0010, 1'b1, 24'h008010, 1'b0, 1'b1},
        '{8'h00, 16'h1234, 1'b1, 24'h001234, 1'b0, 1'b1},
        '{8'h40, 16'hFFFF, 1'b0, 24'h40FFFF, 1'b0, 1'b0},
        '{8'h1F, 16'hFFFF, 1'b0, 24'h1FFFFF, 1'b0, 1'b1},
        '{8'h3F, 16'h0000, 1'b0, 24'h3F0000, 1'b1, 1'b0},
        '{8'h5F, 16'h8001, 1'b1, 24'h7F0001, 1'b0, 1'b0},
        '{8'hFF, 16'h7FFF, 1'b1, 24'hDFFFFF, 1'b0, 1'b0},
        '{8'h00, 16'h0000, 1'b0, 24'h000000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [23:0] ea, input logic er, input logic em);
        check({req, " addr"}, phys_addr, ea);
        check({req, " rom_cs"}, {23'd0, rom_cs}, {23'd0, er});
        check({req, " ram_cs"}, {23'd0, ram_cs}, {23'd0, em});
    endtask

    task automatic load_bank(input logic [7:0] b);
        @(negedge clk);
        phi2    = 1'b0;
        data_in = b;
        @(negedge clk);
        phi2    = 1'b1;
        data_in = 8'hA5;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; phi2 = 1'b0; data_in = 8'h77; addr_in = 16'h1234; emu = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; phi2 = 1'b1;
        #1;
        // R3: bank cleared by reset
        check_out("R3 reset state", 24'h001234, 1'b0, 1'b1);

        // vector table: R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            load_bank(VECS[i].bank);
            addr_in = VECS[i].addr;
            emu     = VECS[i].emu;
            #1;
            check_out(VECS[i].emu ? "R5/R7/R8/R9 emu vec" : "R4/R7/R8/R9 native vec",
                      VECS[i].phys, VECS[i].rom, VECS[i].ram);
        end

        // R1: last byte of the low phase wins
        @(negedge clk); phi2 = 1'b0; data_in = 8'h11; addr_in = 16'h0000; emu = 1'b0;
        @(negedge clk); data_in = 8'h22;
        @(negedge clk); phi2 = 1'b1; data_in = 8'h33;
        #1;
        check("R1 last low byte kept", phys_addr, 24'h220000);

        // R2: data changes during high phase are ignored
        @(negedge clk); data_in = 8'h44;
        @(negedge clk); data_in = 8'h20;
        #1;
        check("R2 hold in high phase", phys_addr, 24'h220000);

        // R10: ROM-decoding address in low phase, no selects
        load_bank(8'h20);
        addr_in = 16'h8000; emu = 1'b0;
        @(negedge clk); phi2 = 1'b0; data_in = 8'h20;
        #1;
        check("R10 rom_cs low phase", {23'd0, rom_cs}, 24'd0);
        check("R10 ram_cs low phase", {23'd0, ram_cs}, 24'd0);

        // R6: emu switch acts without a clock edge
        load_bank(8'h00);
        addr_in = 16'h8000; emu = 1'b0;
        #1;
        check_out("R6 before switch", 24'h008000, 1'b0, 1'b1);
        emu = 1'b1;
        #1;
        check_out("R6 after switch", 24'h200000, 1'b1, 1'b0);

        // R3: reset during high phase clears a loaded bank
        load_bank(8'h20);
        addr_in = 16'h0000; emu = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check_out("R3 reset in high phase", 24'h000000, 1'b0, 1'b1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule